// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave (64 x 16)

This block behaves like a small nonvolatile memory of 64 words of 16 bits, reached over a three-wire serial link: a select line, a serial clock and a serial data input. A separate data output can be released to high impedance; here that is shown as a data bit plus an output-enable. Every serial line is sampled in the system clock domain, so the serial clock has to run several times slower than the system clock. A command frame opens with a start bit, which is the first 1 clocked in after select rises. A two-bit opcode follows it, and then a six-bit field.

Reads give one 0 dummy bit and then as many words as the host keeps clocking. Each word goes out MSB first, and the address moves up by one after each word. Write, erase, write-all and erase-all are all held back by a write-enable latch. A programming operation launches when select falls after a complete frame. A timer set in system clocks then runs, and while it runs a host that raises select reads busy (0) or ready (1) on the data output.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the output enable is low and the write-enable latch is clear, so a WRITE issued before any enable command leaves memory unchanged and starts no busy period.
- R2: The output enable is low whenever select is low.
- R3: While select is high and the frame has not yet started, 0 bits are skipped. The first 1 is taken as the start bit.
- R4: Opcode 2'b10 is READ. On the serial clock rise that captures the last address bit, the output is enabled and drives 0. The next 16 rises each drive one data bit, MSB first.
- R5: If the serial clock keeps running during a read, words from the following addresses are sent with no gap. After address 63 the next address is 0.
- R6: With opcode 2'b00, the top two bits of the six-bit field select a special command: 2'b11 sets the write-enable latch and 2'b00 clears it. While the latch is clear, write and erase commands are ignored but reads still work.
- R7: Opcode 2'b01 is WRITE. It takes a 6-bit address and then 16 data bits MSB first, and it commits only when select falls after the last data bit. If select falls before that, nothing is written.
- R8: Special code 2'b01 (write-all) takes 16 data bits and stores them in all 64 words with one programming cycle.
- R9: Opcode 2'b11 (erase) sets the addressed word to 16'hFFFF. Special code 2'b10 (erase-all) sets every word to 16'hFFFF.
- R10: After a launch, raising select enables the output. It drives 0 for WRITE_CYCLES system clocks after the launch and then 1, and any bits clocked in while it reads 0 are ignored.
- R11: Select falling in the middle of a frame cancels the command. The next frame needs a new start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sel | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock; bits are taken on its rising edge |
| sdi | input | 1 | Serial data in |
| dout | output | 1 | Serial data out / ready-busy status |
| dout_en | output | 1 | Output enable; low means high impedance |

## Verification
A wrong bit counter or a wrong opcode shift register shows at once. The dummy bit either lands on the wrong edge or goes missing, and the next read word comes out shifted, so the first word compare after the fault catches it. A bad write-enable latch or a bad launch condition only shows on the next read-back of the target word, or as a missing or spurious busy phase when select rises after the frame. A timer fault shows as a ready level that arrives too early, or never arrives, within a few hundred clocks of the launch.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HUNT,
        ST_OPC,
        ST_ADDR,
        ST_RDATA,
        ST_WDATA,
        ST_ARMED,
        ST_STATUS,
        ST_DONE
    } mw_state_e;

    typedef enum logic [1:0] {
        OP_SPECIAL = 2'b00,
        OP_WRITE   = 2'b01,
        OP_READ    = 2'b10,
        OP_ERASE   = 2'b11
    } mw_op_e;

    typedef enum logic [1:0] {
        SUB_LOCK   = 2'b00,
        SUB_FILL   = 2'b01,
        SUB_WIPE   = 2'b10,
        SUB_UNLOCK = 2'b11
    } mw_sub_e;

endpackage

// File: rtl/mw_sclk_front.sv
module mw_sclk_front (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic sclk,
    input  logic sdi,
    output logic sel_s,
    output logic sclk_rise,
    output logic sdi_s
);

    logic [2:0] samp_q;
    logic       sclk_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q      <= '0;
            sclk_prev_q <= 1'b0;
        end else begin
            samp_q      <= {sel, sclk, sdi};
            sclk_prev_q <= samp_q[1];
        end
    end

    assign sel_s     = samp_q[2];
    assign sdi_s     = samp_q[0];
    assign sclk_rise = samp_q[1] & ~sclk_prev_q;

endmodule

// File: rtl/mw_word_store.sv
module mw_word_store #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              we,
    input  logic              we_all,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);

    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] words [WORDS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            if (we && (we_all || wr_addr == ADDR_W'(i))) begin
                words[i] <= wr_data;
            end
        end
    end

    assign rd_data = words[rd_addr];

endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
    parameter int CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_pkg::*;
#(
    parameter int ADDR_W       = 6,
    parameter int DATA_W       = 16,
    parameter int WRITE_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic sclk,
    input  logic sdi,
    output logic dout,
    output logic dout_en
);

    localparam int FMAX  = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
    localparam int CNT_W = $clog2(FMAX);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] OPC_LAST  = CNT_W'(1);

    logic sel_s, sclk_rise, sdi_s;
    logic busy;

    mw_state_e st, st_nx;

    logic [CNT_W-1:0]  bit_cnt;
    logic [1:0]        opc_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [ADDR_W-1:0] rd_ptr;
    logic              dout_q;
    logic              wen_q;
    logic              pg_all_q;
    logic              status_pend_q;

    logic [ADDR_W-1:0] full_addr;
    logic [ADDR_W-1:0] rd_sel;
    logic [DATA_W-1:0] rd_word;
    logic              a0_edge;
    logic              start_seen;
    logic              launch;
    mw_op_e            op_e;
    mw_sub_e           sub_e;

    mw_sclk_front u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .sclk      (sclk),
        .sdi       (sdi),
        .sel_s     (sel_s),
        .sclk_rise (sclk_rise),
        .sdi_s     (sdi_s)
    );

    mw_prog_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (launch),
        .busy  (busy)
    );

    mw_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rd_addr (rd_sel),
        .rd_data (rd_word),
        .we      (launch),
        .we_all  (pg_all_q),
        .wr_addr (addr_q),
        .wr_data (data_q)
    );

    assign full_addr  = {addr_q[ADDR_W-2:0], sdi_s};
    assign rd_sel     = (st == ST_ADDR) ? full_addr : rd_ptr;
    assign a0_edge    = (st == ST_ADDR) && sel_s && sclk_rise && (bit_cnt == ADDR_LAST);
    assign start_seen = sclk_rise && sdi_s;
    assign launch     = (st == ST_ARMED) && !sel_s;
    assign op_e       = mw_op_e'(opc_q);
    assign sub_e      = mw_sub_e'(full_addr[ADDR_W-1 -: 2]);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        if (!sel_s) begin
            st_nx = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:   st_nx = (status_pend_q || busy) ? ST_STATUS : ST_HUNT;
                ST_HUNT:   if (start_seen) st_nx = ST_OPC;
                ST_OPC:    if (sclk_rise && bit_cnt == OPC_LAST) st_nx = ST_ADDR;
                ST_ADDR: begin
                    if (a0_edge) begin
                        unique case (op_e)
                            OP_READ:  st_nx = ST_RDATA;
                            OP_WRITE: st_nx = wen_q ? ST_WDATA : ST_DONE;
                            OP_ERASE: st_nx = wen_q ? ST_ARMED : ST_DONE;
                            OP_SPECIAL: begin
                                unique case (sub_e)
                                    SUB_FILL:   st_nx = wen_q ? ST_WDATA : ST_DONE;
                                    SUB_WIPE:   st_nx = wen_q ? ST_ARMED : ST_DONE;
                                    SUB_LOCK:   st_nx = ST_DONE;
                                    SUB_UNLOCK: st_nx = ST_DONE;
                                endcase
                            end
                        endcase
                    end
                end
                ST_WDATA:  if (sclk_rise && bit_cnt == DATA_LAST) st_nx = ST_ARMED;
                ST_STATUS: if (!busy && start_seen) st_nx = ST_OPC;
                ST_RDATA:  st_nx = ST_RDATA;
                ST_ARMED:  st_nx = ST_ARMED;
                ST_DONE:   st_nx = ST_DONE;
                default:   st_nx = ST_IDLE;
            endcase
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt       <= '0;
            opc_q         <= '0;
            addr_q        <= '0;
            data_q        <= '0;
            rd_ptr        <= '0;
            dout_q        <= 1'b0;
            wen_q         <= 1'b0;
            pg_all_q      <= 1'b0;
            status_pend_q <= 1'b0;
        end else begin
            if (launch) begin
                status_pend_q <= 1'b1;
            end else if (st == ST_STATUS && !busy && (!sel_s || start_seen)) begin
                status_pend_q <= 1'b0;
            end

            if (st == ST_IDLE) begin
                bit_cnt <= '0;
            end

            if (sel_s && sclk_rise) begin
                case (st)
                    ST_OPC: begin
                        opc_q   <= {opc_q[0], sdi_s};
                        bit_cnt <= (bit_cnt == OPC_LAST) ? '0 : bit_cnt + CNT_W'(1);
                    end
                    ST_ADDR: begin
                        addr_q <= full_addr;
                        if (bit_cnt == ADDR_LAST) begin
                            bit_cnt <= '0;
                            unique case (op_e)
                                OP_READ: begin
                                    data_q <= rd_word;
                                    dout_q <= 1'b0;
                                    rd_ptr <= full_addr + ADDR_W'(1);
                                end
                                OP_WRITE: pg_all_q <= 1'b0;
                                OP_ERASE: begin
                                    pg_all_q <= 1'b0;
                                    data_q   <= '1;
                                end
                                OP_SPECIAL: begin
                                    unique case (sub_e)
                                        SUB_UNLOCK: wen_q <= 1'b1;
                                        SUB_LOCK:   wen_q <= 1'b0;
                                        SUB_FILL:   pg_all_q <= 1'b1;
                                        SUB_WIPE: begin
                                            pg_all_q <= 1'b1;
                                            data_q   <= '1;
                                        end
                                    endcase
                                end
                            endcase
                        end else begin
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end
                    end
                    ST_WDATA: begin
                        data_q  <= {data_q[DATA_W-2:0], sdi_s};
                        bit_cnt <= (bit_cnt == DATA_LAST) ? '0 : bit_cnt + CNT_W'(1);
                    end
                    ST_RDATA: begin
                        dout_q <= data_q[DATA_W-1];
                        if (bit_cnt == DATA_LAST) begin
                            data_q  <= rd_word;
                            rd_ptr  <= rd_ptr + ADDR_W'(1);
                            bit_cnt <= '0;
                        end else begin
                            data_q  <= data_q << 1;
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        dout_en = 1'b0;
        dout    = 1'b0;
        if (sel_s && st == ST_STATUS) begin
            dout_en = 1'b1;
            dout    = ~busy;
        end else if (sel_s && st == ST_RDATA) begin
            dout_en = 1'b1;
            dout    = dout_q;
        end
    end

endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
    import mw_pkg::*;
#(
    parameter int WRITE_CYCLES = 5000
) (
    input logic      clk,
    input logic      rst_n,
    input logic      sel,
    input logic      sel_s,
    input logic      dout_en,
    input mw_state_e st,
    input logic      busy,
    input logic      wen_q,
    input logic      launch
);

    localparam int RW = $clog2(WRITE_CYCLES + 2);

    logic [RW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (busy) begin
            run_cnt <= run_cnt + RW'(1);
        end else begin
            run_cnt <= '0;
        end
    end

    a_r2_hiz_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && !$past(sel)) |-> !dout_en);

    a_r6_locked_no_program: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> wen_q);

    a_r7_launch_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !sel_s);

    a_r10_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= RW'(WRITE_CYCLES));

    a_r10_no_cmd_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st == ST_STATUS) |=> (st == ST_STATUS || st == ST_IDLE));

endmodule

bind mw_eeprom mw_eeprom_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .sel_s   (sel_s),
    .dout_en (dout_en),
    .st      (st),
    .busy    (busy),
    .wen_q   (wen_q),
    .launch  (launch)
);

// File: tb/sim_mw_eeprom.sv
module sim_mw_eeprom;

    localparam int WCYC = 200;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic dout, dout_en;

    logic [15:0] mdl [64];
    bit mwen = 1'b0;
    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    mw_eeprom #(.ADDR_W(6), .DATA_W(16), .WRITE_CYCLES(WCYC)) u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .sclk(sclk), .sdi(sdi),
        .dout(dout), .dout_en(dout_en)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clk_bit(logic b);
        sdi  = b;
        sclk = 1'b0;
        tick(HALF);
        sclk = 1'b1;
        tick(HALF);
    endtask

    task automatic send(logic [31:0] v, int n);
        for (int i = n - 1; i >= 0; i--) clk_bit(v[i]);
    endtask

    task automatic select_on();
        sel = 1'b1;
        tick(HALF);
    endtask

    task automatic deselect();
        sclk = 1'b0;
        sdi  = 1'b0;
        tick(2);
        sel = 1'b0;
        tick(6);
    endtask

    function automatic logic [15:0] exp_word(logic [5:0] a, int k);
        return mdl[(int'(a) + k) % 64];
    endfunction

    task automatic do_read(logic [5:0] a, int nw, int lead, string tag);
        logic [15:0] w;
        select_on();
        for (int i = 0; i < lead; i++) clk_bit(1'b0);
        send({1'b1, 2'b10, a[5:1]}, 8);
        clk_bit(a[0]);
        chk({tag, " R4 dummy enable"}, dout_en, 1);
        chk({tag, " R4 dummy bit"}, dout, 0);
        for (int k = 0; k < nw; k++) begin
            w = '0;
            for (int b = 0; b < 16; b++) begin
                clk_bit(1'b0);
                w = {w[14:0], dout};
            end
            chk(tag, w, exp_word(a, k));
        end
        deselect();
    endtask

    task automatic wait_ready(string tag);
        int k;
        select_on();
        chk({tag, " R10 status enable"}, dout_en, 1);
        chk({tag, " R10 busy level"}, dout, 0);
        k = 0;
        while (dout !== 1'b1 && k < WCYC + 40) begin
            tick(1);
            k++;
        end
        chk({tag, " R10 ready level"}, dout, 1);
        deselect();
    endtask

    task automatic special(logic [1:0] sub);
        select_on();
        send({1'b1, 2'b00, sub, 4'b0110}, 9);
        deselect();
        if (sub == 2'b11) mwen = 1'b1;
        if (sub == 2'b00) mwen = 1'b0;
    endtask

    task automatic prog(logic [1:0] op, logic [5:0] a, logic [15:0] d, string tag);
        bit all, hasd;
        all  = (op == 2'b00);
        hasd = (op == 2'b01) || (op == 2'b00 && a[5:4] == 2'b01);
        select_on();
        send({1'b1, op, a}, 9);
        if (hasd) send({16'b0, d}, 16);
        deselect();
        if (mwen) begin
            for (int i = 0; i < 64; i++)
                if (all || i == int'(a)) mdl[i] = hasd ? d : 16'hFFFF;
            wait_ready(tag);
        end else begin
            select_on();
            chk({tag, " R6 locked no status"}, dout_en, 0);
            deselect();
        end
    endtask

    initial begin
        tick(190000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [5:0]  ra;
        logic [15:0] rd;
        int          sel_op;
        void'($urandom(32'd4711));
        tick(5);
        rst_n = 1'b1;
        tick(3);
        chk("R1 reset output enable", dout_en, 0);
        select_on();
        chk("R1 no status after reset", dout_en, 0);
        deselect();

        // R1: write before any enable is ignored
        prog(2'b01, 6'd3, 16'h0000, "R1 locked write");

        special(2'b11);
        prog(2'b00, 6'b100000, 16'h0000, "R9 erase-all");
        do_read(6'd3, 2, 0, "R9 erase-all readback");

        // R6: lock, then writes and erases are ignored
        special(2'b00);
        prog(2'b01, 6'd5, 16'h1234, "R6 locked write");
        prog(2'b00, 6'b010000, 16'h5555, "R6 locked fill");
        do_read(6'd5, 1, 0, "R6 read while locked");

        // R1: latch cleared again by reset
        special(2'b11);
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        mwen = 1'b0;
        tick(3);
        prog(2'b01, 6'd6, 16'h0F0F, "R1 write after reset");
        do_read(6'd6, 1, 0, "R1 word kept");

        // R8: fill all, R5 wrap
        special(2'b11);
        prog(2'b00, 6'b010000, 16'hA5C3, "R8 write-all");
        prog(2'b01, 6'd63, 16'h3CC3, "R7 write top");
        prog(2'b01, 6'd0, 16'h8001, "R7 write bottom");
        do_read(6'd62, 4, 0, "R5 wrap read");

        // R9 single erase
        prog(2'b01, 6'd10, 16'h0000, "R7 write ten");
        prog(2'b11, 6'd10, 16'h0000, "R9 erase");
        do_read(6'd9, 3, 0, "R9 erase readback");

        // R3 leading zeros
        do_read(6'd63, 2, 5, "R3 leading zeros");

        // R7 / R11 abort during data
        select_on();
        send({1'b1, 2'b01, 6'd20}, 9);
        send(32'h3C, 8);
        deselect();
        select_on();
        chk("R11 abort no status", dout_en, 0);
        deselect();
        do_read(6'd20, 1, 0, "R7 short write discarded");

        // R11 abort in opcode, then a fresh frame
        select_on();
        send(32'h3, 2);
        deselect();
        do_read(6'd0, 1, 0, "R11 fresh frame after abort");

        // R10 commands ignored while busy
        select_on();
        send({1'b1, 2'b01, 6'd7}, 9);
        send(32'hBEEF, 16);
        deselect();
        mdl[7] = 16'hBEEF;
        select_on();
        chk("R10 busy enable", dout_en, 1);
        chk("R10 busy level", dout, 0);
        send({1'b1, 2'b00, 6'b000000}, 9);
        chk("R10 still busy", dout, 0);
        sclk = 1'b0;
        sdi  = 1'b0;
        begin
            int k;
            k = 0;
            while (dout !== 1'b1 && k < WCYC + 40) begin
                tick(1);
                k++;
            end
        end
        chk("R10 ready after cycle", dout, 1);
        deselect();
        prog(2'b01, 6'd8, 16'h7E57, "R10 write after busy");
        do_read(6'd7, 2, 0, "R10 lock not taken while busy");

        // constrained random mix
        for (int it = 0; it < 24; it++) begin
            sel_op = int'($urandom % 4);
            ra = 6'($urandom);
            rd = 16'($urandom);
            case (sel_op)
                0, 1: prog(2'b01, ra, rd, "R7 random write");
                2: do_read(ra, 1 + int'($urandom % 3), int'($urandom % 3), "R5 random read");
                default: prog(2'b11, ra, 16'h0000, "R9 random erase");
            endcase
        end
        do_read(6'd0, 3, 0, "R4 final read");

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule